// File: doc/BRIEF.md
# Serial flash sector-erase command controller

This block is the slave-side command decoder of a small serial NOR flash. It watches the chip-select, serial-clock and serial-data-in pins through a system-clock synchronizer. It collects an 8-bit opcode and, for the erase command, a 24-bit address that arrives most significant bit first. It holds a write-enable latch and a status byte. When an erase frame is complete and legal, it asks the array interface to fill one whole sector with ones, and it reports the array as busy for a fixed number of system clocks.

Three opcodes are understood. 06h sets the write-enable latch. 05h streams the status byte. D8h erases a sector. The block samples data on the rising serial-clock edge and changes its data output on the falling edge. An erase is carried out only when all of these hold: the write-enable latch is set, chip select rises exactly after the 32nd bit, the upper address byte is zero, and the two protect bits do not cover the target sector. Otherwise the frame is dropped and nothing is reported.

Top module: `nor_erase_ctrl`

## Requirements
- R1: After reset, WIP and WEL read 0, `erase_req_o` is 0 and `miso_o` is 0.
- R2: The status byte has WIP in bit 0, WEL in bit 1 and `protect_i[1:0]` in bits 3:2, with bits 7:4 at 0. Opcode 06h sets WEL, but only when chip select rises after exactly 8 bits.
- R3: After opcode 05h, the status byte is shifted out on `miso_o` MSB first, and each bit changes on a falling serial-clock edge. The byte repeats for as long as chip select stays low.
- R4: Opcode D8h followed by 24 address bits, with chip select rising after exactly 32 bits and WEL set, gives exactly one single-cycle `erase_req_o`. `erase_sector_o` then equals address bits [ADDR_BITS-1:SECTOR_BITS].
- R5: An erase frame ended after any bit count other than 32 (for example 31 or 33) gives no request.
- R6: An erase frame sent while WEL is 0 gives no request.
- R7: Protect value 0 protects nothing. Value 1 protects the upper half of the sectors, meaning those whose index MSB is 1. Values 2 and 3 protect every sector. An erase aimed at a protected sector gives no request.
- R8: An erase frame whose address bits 23:ADDR_BITS are not all zero gives no request.
- R9: WIP reads 1 for exactly ERASE_CYCLES clocks, starting in the cycle of the request. WEL is cleared in that same cycle.
- R10: While WIP is 1, opcode 06h and erase frames have no effect, and opcode 05h still returns the live status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n_i | input | 1 | Chip select, active low |
| sck_i | input | 1 | Serial clock |
| mosi_i | input | 1 | Serial data in |
| protect_i | input | 2 | Block-protect level, reflected in status bits 3:2 |
| miso_o | output | 1 | Serial data out (status byte) |
| erase_req_o | output | 1 | One-cycle sector erase request to the array |
| erase_sector_o | output | ADDR_BITS-SECTOR_BITS | Index of the sector to erase |

## Verification
Every pin passes through two synchronizer flops and one edge-detect register. As a result, a status bit appears on `miso_o` about four clocks after the falling serial-clock edge, and the erase request comes four clocks after chip select rises. The bench holds each serial-clock phase for six clocks and samples `miso_o` just before it raises the clock. It counts request pulses over a twelve-clock window after each frame closes, so a missing, doubled or stray pulse is all caught. WIP is read at the start of the busy window and again after ERASE_CYCLES plus a margin, while the checker counts the busy span to the exact cycle.

// File: rtl/nor_erase_pkg.sv
package nor_erase_pkg;

    localparam logic [7:0] OP_WREN = 8'h06;
    localparam logic [7:0] OP_RDSR = 8'h05;
    localparam logic [7:0] OP_SE   = 8'hD8;

    localparam int FRAME_BITS = 32;
    localparam int CNT_W      = 6;

    typedef struct packed {
        logic              sck_prev;
        logic              cs_prev;
        logic [31:0]       shreg;
        logic [CNT_W-1:0]  cnt;
        logic [7:0]        opcode;
        logic [2:0]        idx;
        logic              miso;
        logic              frame_end;
    } rx_state_t;

endpackage

// File: rtl/nor_in_sync.sv
module nor_in_sync #(
    parameter int             W       = 3,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = async_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{s1: RST_VAL, s2: RST_VAL};
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_o = st_q.s2;
endmodule

// File: rtl/nor_frame_rx.sv
module nor_frame_rx
    import nor_erase_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_s,
    input  logic              sck_s,
    input  logic              mosi_s,
    input  logic [7:0]        status_i,
    output logic              frame_end_o,
    output logic [CNT_W-1:0]  bit_cnt_o,
    output logic [7:0]        opcode_o,
    output logic [23:0]       addr_o,
    output logic              miso_o
);
    rx_state_t st_d, st_q;

    logic sck_rise, sck_fall, cs_fall, cs_rise;

    always_comb begin
        sck_rise = sck_s & ~st_q.sck_prev;
        sck_fall = ~sck_s & st_q.sck_prev;
        cs_fall  = st_q.cs_prev & ~cs_n_s;
        cs_rise  = ~st_q.cs_prev & cs_n_s;

        st_d           = st_q;
        st_d.sck_prev  = sck_s;
        st_d.cs_prev   = cs_n_s;
        st_d.frame_end = 1'b0;

        if (cs_fall) begin
            st_d.cnt    = '0;
            st_d.shreg  = '0;
            st_d.opcode = '0;
            st_d.miso   = 1'b0;
        end else if (cs_rise) begin
            st_d.frame_end = 1'b1;
            st_d.miso      = 1'b0;
        end else if (!cs_n_s) begin
            if (sck_rise) begin
                st_d.shreg = {st_q.shreg[30:0], mosi_s};
                if (st_q.cnt != {CNT_W{1'b1}}) begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
                if (st_q.cnt == CNT_W'(7)) begin
                    st_d.opcode = {st_q.shreg[6:0], mosi_s};
                    st_d.idx    = 3'd7;
                end
            end else if (sck_fall && st_q.cnt >= CNT_W'(8)
                         && st_q.opcode == OP_RDSR) begin
                st_d.miso = status_i[st_q.idx];
                st_d.idx  = st_q.idx - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{sck_prev: 1'b0, cs_prev: 1'b1, shreg: '0, cnt: '0,
                      opcode: '0, idx: 3'd7, miso: 1'b0, frame_end: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign frame_end_o = st_q.frame_end;
    assign bit_cnt_o   = st_q.cnt;
    assign opcode_o    = st_q.opcode;
    assign addr_o      = st_q.shreg[23:0];
    assign miso_o      = st_q.miso;
endmodule

// File: rtl/nor_erase_seq.sv
module nor_erase_seq
    import nor_erase_pkg::*;
#(
    parameter int ADDR_BITS    = 16,
    parameter int SECTOR_BITS  = 15,
    parameter int ERASE_CYCLES = 5000,
    localparam int SW          = ADDR_BITS - SECTOR_BITS,
    localparam int TW          = $clog2(ERASE_CYCLES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_end_i,
    input  logic [CNT_W-1:0]  bit_cnt_i,
    input  logic [7:0]        opcode_i,
    input  logic [23:0]       addr_i,
    input  logic [1:0]        protect_i,
    output logic [7:0]        status_o,
    output logic              wip_o,
    output logic              wel_o,
    output logic              erase_req_o,
    output logic [SW-1:0]     erase_sector_o
);
    typedef struct packed {
        logic          wel;
        logic          wip;
        logic [TW-1:0] timer;
        logic          req;
        logic [SW-1:0] sector;
    } seq_t;

    seq_t st_d, st_q;

    logic [SW-1:0] tgt_sector;
    logic          addr_ok;
    logic          sect_prot;
    logic          se_frame;
    logic          wren_frame;

    always_comb begin
        tgt_sector = addr_i[ADDR_BITS-1:SECTOR_BITS];
        addr_ok    = ((addr_i >> ADDR_BITS) == 24'd0);
        sect_prot  = (protect_i[1]) || (protect_i == 2'b01 && tgt_sector[SW-1]);
        se_frame   = frame_end_i && bit_cnt_i == CNT_W'(FRAME_BITS)
                     && opcode_i == OP_SE;
        wren_frame = frame_end_i && bit_cnt_i == CNT_W'(8)
                     && opcode_i == OP_WREN;

        st_d     = st_q;
        st_d.req = 1'b0;

        if (st_q.wip) begin
            if (st_q.timer == TW'(1)) begin
                st_d.wip   = 1'b0;
                st_d.timer = '0;
            end else begin
                st_d.timer = st_q.timer - 1'b1;
            end
        end else if (wren_frame) begin
            st_d.wel = 1'b1;
        end else if (se_frame && st_q.wel && addr_ok && !sect_prot) begin
            st_d.wip    = 1'b1;
            st_d.timer  = TW'(ERASE_CYCLES);
            st_d.wel    = 1'b0;
            st_d.req    = 1'b1;
            st_d.sector = tgt_sector;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status_o       = {4'b0000, protect_i, st_q.wel, st_q.wip};
    assign wip_o          = st_q.wip;
    assign wel_o          = st_q.wel;
    assign erase_req_o    = st_q.req;
    assign erase_sector_o = st_q.sector;
endmodule

// File: rtl/nor_erase_ctrl.sv
module nor_erase_ctrl
    import nor_erase_pkg::*;
#(
    parameter int ADDR_BITS    = 16,
    parameter int SECTOR_BITS  = 15,
    parameter int ERASE_CYCLES = 5000,
    localparam int SW          = ADDR_BITS - SECTOR_BITS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n_i,
    input  logic          sck_i,
    input  logic          mosi_i,
    input  logic [1:0]    protect_i,
    output logic          miso_o,
    output logic          erase_req_o,
    output logic [SW-1:0] erase_sector_o
);
    logic [2:0]       pins_s;
    logic             frame_end_w;
    logic [CNT_W-1:0] bit_cnt_w;
    logic [7:0]       opcode_w;
    logic [23:0]      addr_w;
    logic [7:0]       status_w;
    logic             wip_w;
    logic             wel_w;

    nor_in_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({cs_n_i, sck_i, mosi_i}),
        .sync_o  (pins_s)
    );

    nor_frame_rx u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_n_s      (pins_s[2]),
        .sck_s       (pins_s[1]),
        .mosi_s      (pins_s[0]),
        .status_i    (status_w),
        .frame_end_o (frame_end_w),
        .bit_cnt_o   (bit_cnt_w),
        .opcode_o    (opcode_w),
        .addr_o      (addr_w),
        .miso_o      (miso_o)
    );

    nor_erase_seq #(
        .ADDR_BITS    (ADDR_BITS),
        .SECTOR_BITS  (SECTOR_BITS),
        .ERASE_CYCLES (ERASE_CYCLES)
    ) u_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .frame_end_i    (frame_end_w),
        .bit_cnt_i      (bit_cnt_w),
        .opcode_i       (opcode_w),
        .addr_i         (addr_w),
        .protect_i      (protect_i),
        .status_o       (status_w),
        .wip_o          (wip_w),
        .wel_o          (wel_w),
        .erase_req_o    (erase_req_o),
        .erase_sector_o (erase_sector_o)
    );
endmodule

// File: rtl/nor_erase_chk.sv
module nor_erase_chk #(
    parameter int ADDR_BITS    = 16,
    parameter int ERASE_CYCLES = 5000
) (
    input logic        clk,
    input logic        rst_n,
    input logic        erase_req,
    input logic        wip,
    input logic        wel,
    input logic        frame_end,
    input logic [23:0] addr,
    input logic [1:0]  protect
);
    logic [31:0] busy_cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_cnt_q <= '0;
        end else if (erase_req) begin
            busy_cnt_q <= 32'd1;
        end else if (wip) begin
            busy_cnt_q <= busy_cnt_q + 32'd1;
        end
    end

    assert_req_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        erase_req |=> !erase_req);

    assert_req_after_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
        erase_req |-> $past(frame_end));

    assert_no_start_when_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        erase_req |-> !$past(wip));

    assert_req_sets_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        erase_req |-> (wip && !wel));

    assert_req_needs_wel_R6: assert property (@(posedge clk) disable iff (!rst_n)
        erase_req |-> $past(wel));

    assert_req_unprotected_R7: assert property (@(posedge clk) disable iff (!rst_n)
        erase_req |-> !$past(protect[1]));

    assert_req_addr_hi_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        erase_req |-> (($past(addr) >> ADDR_BITS) == 24'd0));

    assert_busy_length_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wip) |-> busy_cnt_q == 32'(ERASE_CYCLES));
endmodule

bind nor_erase_ctrl nor_erase_chk #(
    .ADDR_BITS    (ADDR_BITS),
    .ERASE_CYCLES (ERASE_CYCLES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .erase_req (erase_req_o),
    .wip       (wip_w),
    .wel       (wel_w),
    .frame_end (frame_end_w),
    .addr      (addr_w),
    .protect   (protect_i)
);

// File: tb/test_nor_erase_ctrl.sv
module test_nor_erase_ctrl;
    localparam int ADDR_BITS    = 16;
    localparam int SECTOR_BITS  = 15;
    localparam int ERASE_CYCLES = 1500;
    localparam int HALF         = 6;
    localparam int NVEC         = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sck = 1'b0;
    logic mosi = 1'b0;
    logic [1:0] prot = 2'b00;
    logic miso;
    logic erase_req;
    logic [0:0] erase_sector;

    int n_tests = 0;
    int n_fail  = 0;
    int pulses  = 0;
    logic [0:0] last_sector = '0;

    always #4 clk = ~clk;

    nor_erase_ctrl #(
        .ADDR_BITS    (ADDR_BITS),
        .SECTOR_BITS  (SECTOR_BITS),
        .ERASE_CYCLES (ERASE_CYCLES)
    ) i_nor_erase_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .cs_n_i         (cs_n),
        .sck_i          (sck),
        .mosi_i         (mosi),
        .protect_i      (prot),
        .miso_o         (miso),
        .erase_req_o    (erase_req),
        .erase_sector_o (erase_sector)
    );

    always @(posedge clk) begin
        if (rst_n && erase_req) begin
            pulses      <= pulses + 1;
            last_sector <= erase_sector;
        end
    end

    // vector: prot[34:33] wren[32] nbits[31:26] addr[25:2] exp_pulse[1] exp_sector[0]
    localparam logic [34:0] VEC [NVEC] = '{
        {2'd0, 1'b1, 6'd32, 24'h000000, 1'b1, 1'b0},  // R4 sector 0
        {2'd0, 1'b1, 6'd32, 24'h008123, 1'b1, 1'b1},  // R4 sector 1
        {2'd0, 1'b0, 6'd32, 24'h000010, 1'b0, 1'b0},  // R6 no WEL
        {2'd0, 1'b1, 6'd31, 24'h000000, 1'b0, 1'b0},  // R5 short
        {2'd0, 1'b1, 6'd33, 24'h000000, 1'b0, 1'b0},  // R5 long
        {2'd1, 1'b1, 6'd32, 24'h008000, 1'b0, 1'b0},  // R7 upper protected
        {2'd1, 1'b1, 6'd32, 24'h004000, 1'b1, 1'b0},  // R7 lower open
        {2'd2, 1'b1, 6'd32, 24'h000000, 1'b0, 1'b0},  // R7 all protected
        {2'd0, 1'b1, 6'd32, 24'h010000, 1'b0, 1'b0},  // R8 A16 set
        {2'd3, 1'b1, 6'd32, 24'h008000, 1'b0, 1'b0},  // R7 all protected
        {2'd1, 1'b1, 6'd32, 24'h007FFF, 1'b1, 1'b0},  // R7 boundary
        {2'd0, 1'b1, 6'd32, 24'h00FFFF, 1'b1, 1'b1}   // R4 top address
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic frame_begin();
        @(negedge clk);
        cs_n = 1'b0;
        cyc(HALF);
    endtask

    task automatic frame_end();
        cyc(HALF);
        @(negedge clk);
        cs_n = 1'b1;
        cyc(2 * HALF);
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        mosi = b;
        cyc(HALF);
        @(negedge clk);
        sck = 1'b1;
        cyc(HALF);
        @(negedge clk);
        sck = 1'b0;
    endtask

    task automatic recv_byte(output logic [7:0] v);
        for (int i = 7; i >= 0; i--) begin
            cyc(HALF);
            @(negedge clk);
            v[i] = miso;
            sck = 1'b1;
            cyc(HALF);
            @(negedge clk);
            sck = 1'b0;
        end
    endtask

    task automatic send_op(input logic [7:0] op, input int nbits);
        for (int i = 0; i < nbits; i++) begin
            send_bit(i < 8 ? op[7-i] : 1'b0);
        end
    endtask

    task automatic cmd_wren();
        frame_begin();
        send_op(8'h06, 8);
        frame_end();
    endtask

    task automatic read_status(output logic [7:0] v);
        frame_begin();
        send_op(8'h05, 8);
        recv_byte(v);
        frame_end();
    endtask

    task automatic cmd_erase(input logic [23:0] addr, input int nbits);
        logic [31:0] w;
        w = {8'hD8, addr};
        frame_begin();
        for (int i = 0; i < nbits; i++) begin
            send_bit(i < 32 ? w[31-i] : 1'b0);
        end
        frame_end();
    endtask

    initial begin
        #2_000_000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual 0x0 expected 0x1");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] st, st2;
        int p0;

        cyc(5);
        @(negedge clk);
        rst_n = 1'b1;
        cyc(3);
        @(negedge clk);
        check(miso == 1'b0, "R1 miso", miso, 0);
        check(erase_req == 1'b0, "R1 req", erase_req, 0);
        read_status(st);
        check(st == 8'h00, "R1 status", st, 8'h00);

        prot = 2'b01;
        read_status(st);
        check(st == 8'h04, "R2 protect field", st, 8'h04);

        frame_begin();
        send_op(8'h06, 9);
        frame_end();
        read_status(st);
        check(st == 8'h04, "R2 wren 9 bits", st, 8'h04);

        cmd_wren();
        read_status(st);
        check(st == 8'h06, "R2 wren sets WEL", st, 8'h06);

        frame_begin();
        send_op(8'h05, 8);
        recv_byte(st);
        recv_byte(st2);
        frame_end();
        check(st == 8'h06, "R3 first byte", st, 8'h06);
        check(st2 == 8'h06, "R3 repeated byte", st2, 8'h06);
        prot = 2'b00;

        for (int v = 0; v < NVEC; v++) begin
            logic [34:0] e;
            e = VEC[v];
            prot = e[34:33];
            if (e[32]) cmd_wren();
            p0 = pulses;
            cmd_erase(e[25:2], int'(e[31:26]));
            check((pulses - p0) == int'(e[1]), "R4-R8 pulse count", pulses - p0, int'(e[1]));
            if (e[1]) begin
                check(last_sector == e[0], "R4 sector index", last_sector, e[0]);
                cyc(ERASE_CYCLES + 100);
                read_status(st);
                check(st == {4'b0, prot, 2'b00}, "R9 status after erase", st, {4'b0, prot, 2'b00});
            end
        end

        prot = 2'b00;
        cmd_wren();
        p0 = pulses;
        cmd_erase(24'h000100, 32);
        check((pulses - p0) == 1, "R4 erase start", pulses - p0, 1);
        read_status(st);
        check(st == 8'h01, "R9 WIP set WEL clear", st, 8'h01);
        cmd_wren();
        read_status(st);
        check(st == 8'h01, "R10 wren ignored busy", st, 8'h01);
        p0 = pulses;
        cmd_erase(24'h000000, 32);
        check(pulses == p0, "R10 erase ignored busy", pulses - p0, 0);
        cyc(ERASE_CYCLES);
        read_status(st);
        check(st == 8'h00, "R9 WIP cleared", st, 8'h00);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule